// File: doc/BRIEF.md
# Real-Time Path Partition Table Generator

This block produces routing words for a reduction circuit that folds a serial stream of operands into per-set results. The circuit uses a single adder with a four-stage pipeline. Elements arrive one per clock, together with a strobe that marks the last element of a set. The stream is cut into iterations of four consecutive cycles. Inside one iteration the elements meet in a fixed tree. Two leaf nodes each join a pair of slots. A join node combines the two leaves. A carry node then adds the join result to the partial result carried from the previous iteration. This block decides, from the valid and end-of-set strobes alone, which of those tree nodes each element really passes through. It also decides which operand port the element enters at each node, the absolute cycle at which each node executes, and whether the element's path ends with a final result or with a partial result that goes on to the next iteration.

Sets of any length, and any number of sets, may share an iteration or span several iterations. An idle slot is a bubble: it carries no path and does not break the set it sits in. The routing words of one iteration are settled when its last slot arrives. They leave the block four cycles after their elements, one word per cycle, in slot order. A downstream routing pipeline of the same depth as the adder receives them.

Top module: `rt_path_partition`

## Requirements
- R1: While reset is held, and during the first four cycles after it is released, out_valid is 0 and every hop field (used bits, times, operand codes) and out_tni read zero.
- R2: After reset, cycle c belongs to iteration k = c/4 at slot s = c mod 4. The word for the input of cycle c appears during cycle c+4, and out_valid there equals that cycle's din_valid.
- R3: Node execution cycles for iteration k, taken modulo 2^TIME_W, are 4k+1 for the lower leaf, 4k+3 for the upper leaf, 4k+8 for the join node and 4k+14 for the carry node. An unused hop reports time 0.
- R4: Hop 0 is the leaf node (lower leaf for slots 0 and 1, upper leaf for slots 2 and 3), hop 1 is the join node and hop 2 is the carry node. Operand codes are 1 for the first operand and 2 for the second. Hop 0 uses code 1 for even slots and 2 for odd slots. Hop 1 uses code 1 for slots 0 and 1 and code 2 for slots 2 and 3. Hop 2 always uses code 2. An unused hop reports code 0.
- R5: An element whose set has no end marker in the current iteration keeps every node of its default path except the nodes claimed by sets that end in this iteration, and its out_tni is 1.
- R6: A set that ends in the iteration claims a node exactly when both operand sides of that node hold data of the set. The carry node's first side counts only when the set already had elements in an earlier iteration. An element of such a set keeps only the claimed nodes of its default path. For example, a ninth element that arrives alone behind a carried partial keeps only its carry node, at 4k+14.
- R7: Every valid element whose set ends in the current iteration reports out_tni = 0.
- R8: A cycle with din_valid low yields a word with out_valid 0, no used hops and out_tni 0. set_end is ignored in that cycle. The surrounding set continues across the bubble, including across iteration boundaries.
- R9: A set of a single element with no carried partial reports an empty path (no used hops) and out_tni 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_valid | input | 1 | Current slot holds an element |
| set_end | input | 1 | Current element closes its set |
| out_valid | output | 1 | Word describes a real element |
| out_tni | output | 1 | 1: path ends in a partial for the next iteration; 0: final result |
| out_hop_used | output | 3 | Bit h set when hop h (leaf, join, carry) is on the path |
| out_hop_time | output | 3*TIME_W | Execution cycle per hop, hop h at bits h*TIME_W upward |
| out_hop_opnd | output | 6 | Operand code per hop, two bits each, hop h at bits 2h upward |

## Verification
The bench builds the block with TIME_W = 16. That width covers the whole run of a few thousand cycles without wrap, so every node time can be compared as a plain sum of iteration base and offset. A directed opening places a nine-element set so that its last element lands alone in iteration 2. This brings the shrunken carry-only path and the trimmed path of the following open set within reach, together with a lone single-element set and a bubble. Random set lengths from one to eleven, mixed with bubbles and with stray end strobes on idle slots, then cover sets that straddle iterations, sets that end and start inside one iteration, and carries across bubbles.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int SLOTS  = 4;
    localparam int HOPS   = 3;
    localparam int NODES  = 4;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int GRP_W  = $clog2(SLOTS + 1);

    typedef enum logic [1:0] {
        ND_LEAF_LO = 2'd0,
        ND_LEAF_HI = 2'd1,
        ND_JOIN    = 2'd2,
        ND_CARRY   = 2'd3
    } node_e;

    typedef struct packed {
        logic       used;
        logic [1:0] opnd;
        node_e      node;
    } hop_t;

    typedef struct packed {
        logic                 valid;
        logic                 tni;
        hop_t [HOPS-1:0]      hop;
    } word_t;

    // default node visited by a slot at a given hop
    function automatic node_e hop_node(int slot, int hop);
        case (hop)
            0:       return (slot < 2) ? ND_LEAF_LO : ND_LEAF_HI;
            1:       return ND_JOIN;
            default: return ND_CARRY;
        endcase
    endfunction

    // operand port code (1 = first, 2 = second) of a slot at a hop
    function automatic logic [1:0] hop_opnd(int slot, int hop);
        case (hop)
            0:       return (slot % 2 == 1) ? 2'd2 : 2'd1;
            1:       return (slot >= 2) ? 2'd2 : 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // slots feeding the first operand side of a node
    function automatic logic [SLOTS-1:0] node_lmask(node_e n);
        case (n)
            ND_LEAF_LO: return 4'b0001;
            ND_LEAF_HI: return 4'b0100;
            ND_JOIN:    return 4'b0011;
            default:    return 4'b0000;
        endcase
    endfunction

    // slots feeding the second operand side of a node
    function automatic logic [SLOTS-1:0] node_rmask(node_e n);
        case (n)
            ND_LEAF_LO: return 4'b0010;
            ND_LEAF_HI: return 4'b1000;
            ND_JOIN:    return 4'b1100;
            default:    return 4'b1111;
        endcase
    endfunction

    // execution cycle of a node relative to its iteration base
    function automatic logic [4:0] node_offset(node_e n);
        case (n)
            ND_LEAF_LO: return 5'd1;
            ND_LEAF_HI: return 5'd3;
            ND_JOIN:    return 5'd8;
            default:    return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rt_slot_clock.sv
module rt_slot_clock
    import rt_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot,
    output logic              last_slot,
    output logic [TIME_W-1:0] base
);

    assign last_slot = (slot == SLOT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            base <= '0;
        end else begin
            slot <= slot + SLOT_W'(1);
            if (last_slot)
                base <= base + TIME_W'(SLOTS);
        end
    end

endmodule

// File: rtl/rt_slot_capture.sv
module rt_slot_capture
    import rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot,
    input  logic              din_valid,
    input  logic              set_end,
    output logic [SLOTS-1:0]  slot_v,
    output logic [SLOTS-1:0]  slot_e
);

    logic [SLOTS-2:0] v_q;
    logic [SLOTS-2:0] e_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            e_q <= '0;
        end else begin
            for (int s = 0; s < SLOTS - 1; s++) begin
                if (slot == SLOT_W'(s)) begin
                    v_q[s] <= din_valid;
                    e_q[s] <= din_valid && set_end;
                end
            end
        end
    end

    // last slot of the iteration is taken straight from the inputs
    assign slot_v = {din_valid, v_q};
    assign slot_e = {din_valid && set_end, e_q};

endmodule

// File: rtl/rt_claim_unit.sv
module rt_claim_unit
    import rt_pkg::*;
(
    input  logic [SLOTS-1:0]        slot_v,
    input  logic [SLOTS-1:0]        slot_e,
    input  logic                    carry_in,
    output word_t [SLOTS-1:0]       words,
    output logic                    carry_out
);

    logic [GRP_W-1:0] grp [SLOTS];
    logic [GRP_W-1:0] open_grp;
    logic [SLOTS-1:0] member [SLOTS+1];
    logic [SLOTS:0]   ended;
    logic [NODES-1:0] claimed;
    logic [GRP_W-1:0] claim_grp [NODES];

    // group numbering: a new group starts after every closing element
    always_comb begin
        logic [GRP_W-1:0] g;
        g = '0;
        for (int s = 0; s < SLOTS; s++) begin
            grp[s] = g;
            if (slot_v[s] && slot_e[s])
                g = g + GRP_W'(1);
        end
        open_grp = g;
        for (int k = 0; k <= SLOTS; k++) begin
            member[k] = '0;
            ended[k]  = 1'b0;
        end
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_v[s]) begin
                member[grp[s]][s] = 1'b1;
                if (slot_e[s])
                    ended[grp[s]] = 1'b1;
            end
        end
    end

    // node claims: a closing group takes a node when both sides hold it
    always_comb begin
        logic lhs;
        logic rhs;
        for (int n = 0; n < NODES; n++) begin
            claimed[n]   = 1'b0;
            claim_grp[n] = '0;
            for (int k = 0; k < SLOTS; k++) begin
                lhs = (|(member[k] & node_lmask(node_e'(n))))
                      || (n == int'(ND_CARRY) && k == 0 && carry_in);
                rhs = |(member[k] & node_rmask(node_e'(n)));
                if (ended[k] && lhs && rhs) begin
                    claimed[n]   = 1'b1;
                    claim_grp[n] = GRP_W'(k);
                end
            end
        end
    end

    assign carry_out = (|member[open_grp]) || (carry_in && open_grp == '0);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        word_t w;
        always_comb begin
            node_e nd;
            logic  keep;
            w       = '0;
            w.valid = slot_v[s];
            w.tni   = slot_v[s] && !ended[grp[s]];
            for (int h = 0; h < HOPS; h++) begin
                nd   = hop_node(s, h);
                keep = slot_v[s] && (ended[grp[s]]
                       ? (claimed[nd] && claim_grp[nd] == grp[s])
                       : !claimed[nd]);
                if (keep) begin
                    w.hop[h].used = 1'b1;
                    w.hop[h].opnd = hop_opnd(s, h);
                    w.hop[h].node = nd;
                end
            end
        end
        assign words[s] = w;
    end

endmodule

// File: rtl/rt_table_bank.sv
module rt_table_bank
    import rt_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  word_t [SLOTS-1:0] words_in,
    input  logic              carry_next,
    input  logic [TIME_W-1:0] base_in,
    input  logic [SLOT_W-1:0] slot,
    output word_t             word_out,
    output logic [TIME_W-1:0] base_out,
    output logic              carry_q
);

    word_t [SLOTS-1:0] bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank     <= '0;
            base_out <= '0;
            carry_q  <= 1'b0;
        end else if (load) begin
            bank     <= words_in;
            base_out <= base_in;
            carry_q  <= carry_next;
        end
    end

    assign word_out = bank[slot];

endmodule

// File: rtl/rt_path_partition.sv
module rt_path_partition
    import rt_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   din_valid,
    input  logic                   set_end,
    output logic                   out_valid,
    output logic                   out_tni,
    output logic [HOPS-1:0]        out_hop_used,
    output logic [HOPS*TIME_W-1:0] out_hop_time,
    output logic [2*HOPS-1:0]      out_hop_opnd
);

    logic [SLOT_W-1:0] slot;
    logic              last_slot;
    logic [TIME_W-1:0] base;
    logic [SLOTS-1:0]  slot_v;
    logic [SLOTS-1:0]  slot_e;
    word_t [SLOTS-1:0] words;
    logic              carry_q;
    logic              carry_next;
    word_t             word_out;
    logic [TIME_W-1:0] base_out;

    rt_slot_clock #(.TIME_W(TIME_W)) u_clock (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .last_slot (last_slot),
        .base      (base)
    );

    rt_slot_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .din_valid (din_valid),
        .set_end   (set_end),
        .slot_v    (slot_v),
        .slot_e    (slot_e)
    );

    rt_claim_unit u_claim (
        .slot_v    (slot_v),
        .slot_e    (slot_e),
        .carry_in  (carry_q),
        .words     (words),
        .carry_out (carry_next)
    );

    rt_table_bank #(.TIME_W(TIME_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load       (last_slot),
        .words_in   (words),
        .carry_next (carry_next),
        .base_in    (base),
        .slot       (slot),
        .word_out   (word_out),
        .base_out   (base_out),
        .carry_q    (carry_q)
    );

    assign out_valid = word_out.valid;
    assign out_tni   = word_out.tni;

    for (genvar h = 0; h < HOPS; h++) begin : g_hop
        assign out_hop_used[h] = word_out.hop[h].used;
        assign out_hop_opnd[2*h +: 2] = word_out.hop[h].opnd;
        assign out_hop_time[h*TIME_W +: TIME_W] = word_out.hop[h].used
            ? base_out + TIME_W'(node_offset(word_out.hop[h].node))
            : '0;
    end

endmodule

// File: rtl/rt_path_partition_chk.sv
module rt_path_partition_chk #(
    parameter int TIME_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                din_valid,
    input logic                set_end,
    input logic                out_valid,
    input logic                out_tni,
    input logic [2:0]          out_hop_used,
    input logic [3*TIME_W-1:0] out_hop_time,
    input logic [5:0]          out_hop_opnd
);

    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 3'd4)
            age <= age + 3'd1;
    end

    // R1
    startup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (age < 3'd4) |-> (!out_valid && out_hop_used == 3'b000));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4) |-> (out_valid == $past(din_valid, 4)));

    // R7
    closing_tni_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4 && $past(din_valid && set_end, 4)) |-> !out_tni);

    // R8
    bubble_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_hop_used == 3'b000 && !out_tni));

    // R3
    join_carry_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_hop_used[1] && out_hop_used[2]) |->
        (out_hop_time[3*TIME_W-1:2*TIME_W] - out_hop_time[2*TIME_W-1:TIME_W]
         == TIME_W'(6)));

    // R4
    carry_port_chk: assert property (@(posedge clk) disable iff (rst)
        out_hop_used[2] |-> (out_hop_opnd[5:4] == 2'd2));

endmodule

bind rt_path_partition rt_path_partition_chk #(.TIME_W(TIME_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .din_valid    (din_valid),
    .set_end      (set_end),
    .out_valid    (out_valid),
    .out_tni      (out_tni),
    .out_hop_used (out_hop_used),
    .out_hop_time (out_hop_time),
    .out_hop_opnd (out_hop_opnd)
);

// File: tb/sim_rt_path_partition.sv
module sim_rt_path_partition;

    localparam int CLK_PERIOD = 10;
    localparam int TW   = 16;
    localparam int NCYC = 2440;
    localparam int NARR = NCYC + 8;

    logic clk = 1'b0;
    logic rst;
    logic din_valid;
    logic set_end;
    logic          out_valid;
    logic          out_tni;
    logic [2:0]    out_hop_used;
    logic [3*TW-1:0] out_hop_time;
    logic [5:0]    out_hop_opnd;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_path_partition #(.TIME_W(TW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .din_valid    (din_valid),
        .set_end      (set_end),
        .out_valid    (out_valid),
        .out_tni      (out_tni),
        .out_hop_used (out_hop_used),
        .out_hop_time (out_hop_time),
        .out_hop_opnd (out_hop_opnd)
    );

    int compared = 0;
    int mismatched = 0;

    bit          ex_v  [NARR];
    bit          ex_t  [NARR];
    logic [2:0]  ex_u  [NARR];
    logic [3*TW-1:0] ex_tm [NARR];
    logic [5:0]  ex_op [NARR];

    bit bv [4];
    bit be [4];
    bit carry_m = 1'b0;
    int set_of [4];

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input int c);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, c, act, exp);
        end
    endtask

    // does the given side of a node hold data of set j (carry side included)
    function automatic bit side_has(input int n, input int side, input int j);
        int lo, hi;
        bit r;
        r = 1'b0;
        case (n)
            0: begin lo = side ? 1 : 0; hi = lo; end
            1: begin lo = side ? 3 : 2; hi = lo; end
            2: begin lo = side ? 2 : 0; hi = lo + 1; end
            default: begin lo = side ? 0 : 4; hi = side ? 3 : 3; end
        endcase
        for (int t = lo; t <= hi; t++)
            if (bv[t] && set_of[t] == j) r = 1'b1;
        if (n == 3 && side == 0 && j == 0 && carry_m) r = 1'b1;
        return r;
    endfunction

    task automatic model_iter(input int base_c);
        int k;
        int claimer [4];
        bit fin [5];
        bit open_has;
        int offs [4];
        offs = '{1, 3, 8, 14};
        k = 0;
        for (int s = 0; s < 4; s++) begin
            set_of[s] = k;
            if (bv[s] && be[s]) k++;
        end
        for (int j = 0; j < 5; j++) fin[j] = 1'b0;
        for (int s = 0; s < 4; s++) if (bv[s] && be[s]) fin[set_of[s]] = 1'b1;
        for (int n = 0; n < 4; n++) begin
            claimer[n] = -1;
            for (int j = 0; j < 4; j++)
                if (fin[j] && side_has(n, 0, j) && side_has(n, 1, j)) claimer[n] = j;
        end
        for (int s = 0; s < 4; s++) begin
            int idx;
            idx = base_c + 4 + s;
            ex_v[idx] = bv[s];
            ex_t[idx] = bv[s] && !fin[set_of[s]];
            ex_u[idx] = '0;
            ex_tm[idx] = '0;
            ex_op[idx] = '0;
            for (int h = 0; h < 3; h++) begin
                int nd;
                bit keep;
                logic [1:0] op;
                nd = (h == 0) ? ((s < 2) ? 0 : 1) : ((h == 1) ? 2 : 3);
                op = (h == 0) ? ((s % 2 == 1) ? 2'd2 : 2'd1)
                   : (h == 1) ? ((s >= 2) ? 2'd2 : 2'd1) : 2'd2;
                keep = bv[s] && (fin[set_of[s]] ? (claimer[nd] == set_of[s])
                                                : (claimer[nd] < 0));
                if (keep) begin
                    ex_u[idx][h] = 1'b1;
                    ex_op[idx][2*h +: 2] = op;
                    ex_tm[idx][h*TW +: TW] = TW'(base_c + offs[nd]);
                end
            end
        end
        open_has = 1'b0;
        for (int s = 0; s < 4; s++) if (bv[s] && set_of[s] == k) open_has = 1'b1;
        carry_m = open_has || (carry_m && k == 0);
    endtask

    task automatic check_cycle(input int c);
        if (c < 4) begin
            chk("R1 valid", 64'(out_valid), 64'd0, c);
            chk("R1 hops", 64'(out_hop_used), 64'd0, c);
            chk("R1 times", 64'(out_hop_time), 64'd0, c);
            chk("R1 tni", 64'(out_tni), 64'd0, c);
        end else begin
            chk("R2 valid", 64'(out_valid), 64'(ex_v[c]), c);
            if (!ex_v[c]) chk("R8 tni", 64'(out_tni), 64'(ex_t[c]), c);
            else if (ex_t[c]) chk("R5 tni", 64'(out_tni), 64'(ex_t[c]), c);
            else chk("R7 tni", 64'(out_tni), 64'(ex_t[c]), c);
            chk("R6 hops", 64'(out_hop_used), 64'(ex_u[c]), c);
            chk("R3 times", 64'(out_hop_time), 64'(ex_tm[c]), c);
            chk("R4 operands", 64'(out_hop_opnd), 64'(ex_op[c]), c);
        end
        // directed literals for the opening sequence
        if (c == 12) begin
            chk("R6 lone last element hops", 64'(out_hop_used), 64'b100, c);
            chk("R6 lone last element time", 64'(out_hop_time[3*TW-1:2*TW]), 64'd22, c);
            chk("R7 lone last element tni", 64'(out_tni), 64'd0, c);
        end
        if (c == 13) begin
            chk("R5 trimmed open hops", 64'(out_hop_used), 64'b011, c);
            chk("R5 trimmed open times", 64'(out_hop_time[2*TW-1:0]),
                {32'd0, 16'd16, 16'd9}, c);
            chk("R5 trimmed open tni", 64'(out_tni), 64'd1, c);
        end
        if (c == 17) begin
            chk("R9 single set hops", 64'(out_hop_used), 64'd0, c);
            chk("R9 single set tni", 64'(out_tni), 64'd0, c);
        end
        if (c == 18) chk("R8 bubble valid", 64'(out_valid), 64'd0, c);
    endtask

    initial begin
        int rem;
        int seed_sink;
        bit v, e;
        seed_sink = $urandom(32'd2024);
        rem = 0;
        rst = 1'b1;
        din_valid = 1'b0;
        set_end = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            check_cycle(c);
            if (c < 16) begin
                v = (c != 14);
                e = (c == 8 || c == 12 || c == 13 || c == 15);
            end else if (c < NCYC - 8) begin
                v = ($urandom % 5) != 0;
                if (v) begin
                    if (rem == 0) rem = 1 + int'($urandom % 11);
                    e = (rem == 1);
                    rem--;
                end else begin
                    e = ($urandom % 3) == 0;
                end
            end else begin
                v = 1'b0;
                e = 1'b0;
            end
            din_valid = v;
            set_end = e;
            bv[c % 4] = v;
            be[c % 4] = v && e;
            if (c % 4 == 3) model_iter(c - 3);
            @(negedge clk);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule